// File: doc/BRIEF.md
# Reconfigurable Stream Routing Fabric

This block joins data sources, processing-unit slots and data sinks into a processing chain that software picks at run time. Every endpoint has a fixed style, chosen by parameter. A push endpoint moves data when its producer raises a strobe. A pull endpoint moves data when its consumer raises a request and the producer answers. All ports share one timing rule: the data word is valid in the clock cycle after its strobe or request.

The fabric sees two kinds of endpoint. Upstream endpoints produce data: the sources and the output sides of the processing units. Downstream endpoints consume data: the sinks and the input sides of the processing units. Each downstream endpoint has its own route register, which names the upstream endpoint that feeds it. A chain source → unit → sink takes two routes. A bypass is simply a sink routed straight to a source.

For push-to-push routes the fabric multiplexes the strobe and the data. For pull-to-pull routes it steers the consumer's request to the chosen producer and brings the answer back. When a pull consumer is fed by a push producer, a one-word holding register sits between them.

Top module: `stream_route_fabric`

## Requirements
- R1: After reset every route is disabled, and all of `up_req_o`, `dn_stb_o`, `dn_dat_o` and `dn_ovr_o` are zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the route register of downstream `cfg_addr`. Downstream 0-3 are sinks and 4-5 are unit inputs. Bit 3 is the enable and bits 2:0 are the upstream index, where 0-3 are sources and 4-5 are unit outputs. The write acts from the following cycle. A write to an address of 6 or more changes nothing.
- R3: An enabled route whose upstream index is 6 or more behaves exactly like a disabled route.
- R4: On a push upstream → push downstream route, `dn_stb_o` and `dn_dat_o` follow the upstream strobe and data in the same cycle, so the one-cycle strobe-to-data spacing is kept.
- R5: On a pull downstream → pull upstream route, the downstream request appears on `up_req_o` of the chosen upstream in the same cycle. Requests from several pull routes to one upstream are ORed. `dn_dat_o` carries that upstream's data, so the answer arrives in the cycle after the request.
- R6: An upstream not chosen by an active pull route sees no request. A disabled downstream sees no strobe and zero data.
- R7: A pull upstream routed to a push downstream is idle: no request, no strobe, zero data.
- R8: On a push upstream → pull downstream route, the word that arrives the cycle after the upstream strobe is captured. A request while a word is held returns that word on `dn_dat_o` in the next cycle and empties the register. In every other cycle `dn_dat_o` is zero.
- R9: `dn_ovr_o` pulses in the cycle a new word arrives while an unread word is held and no request drains it. The newer word replaces the older one.
- R10: Any change that takes a downstream off a push → pull route discards its held word.
- R11: A unit chain works end to end. A unit input routed from a source, plus a sink routed from that unit's output, passes strobes and data through both hops with push timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Route register write enable |
| cfg_addr | input | 3 | Downstream index to write |
| cfg_wdata | input | 4 | {enable, upstream index} |
| up_stb_i | input | 6 | Strobes from push upstream endpoints |
| up_req_o | output | 6 | Requests to pull upstream endpoints |
| up_dat_i | input | 48 | Upstream data, 8 bits per endpoint |
| dn_stb_o | output | 6 | Strobes to push downstream endpoints |
| dn_req_i | input | 6 | Requests from pull downstream endpoints |
| dn_dat_o | output | 48 | Downstream data, 8 bits per endpoint |
| dn_ovr_o | output | 6 | Holding-register overrun pulse per downstream |

## Verification
The bench aims at the push → pull holding path. A request and a new word in the same cycle must return the old word and keep the new one; a design that cleared the full flag first would drop data. A second word with no read in between must pulse overrun exactly once; a design that checked the flag a cycle late would miss it. The bench writes route registers at invalid addresses and with out-of-range indices, and routes a pull source to a push sink. A design that decoded any of these loosely would leak strobes or requests to an endpoint that was never chosen. Rerouting a loaded holding register must discard its word; otherwise stale data reaches a new chain.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [1:0] {
    RT_OFF  = 2'd0,
    RT_PUSH = 2'd1,
    RT_PULL = 2'd2,
    RT_HOLD = 2'd3
  } route_t;

  // Route style from the endpoint styles at both ends
  function automatic route_t classify(input logic en, input logic in_range,
                                      input logic up_pull, input logic dn_pull);
    if (!en || !in_range)        return RT_OFF;
    else if (!up_pull && !dn_pull) return RT_PUSH;
    else if (up_pull && dn_pull)   return RT_PULL;
    else if (!up_pull && dn_pull)  return RT_HOLD;
    else                           return RT_OFF;
  endfunction

endpackage

// File: rtl/srf_cfg_regs.sv
module srf_cfg_regs #(
  parameter int ND   = 6,
  parameter int SELW = 3,
  parameter int AW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [SELW:0]      wdata,
  output logic [ND-1:0]      en_o,
  output logic [ND*SELW-1:0] sel_o
);

  logic addr_ok;
  assign addr_ok = int'(addr) < ND;

  for (genvar d = 0; d < ND; d++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_o[d]                <= 1'b0;
        sel_o[d*SELW +: SELW]  <= '0;
      end else if (we && addr_ok && int'(addr) == d) begin
        en_o[d]                <= wdata[SELW];
        sel_o[d*SELW +: SELW]  <= wdata[SELW-1:0];
      end
    end
  end

  // R2
  bad_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr_ok) |=> ($stable(en_o) && $stable(sel_o)));

endmodule

// File: rtl/srf_down_port.sv
module srf_down_port
  import srf_pkg::*;
#(
  parameter int            NU         = 6,
  parameter int            W          = 8,
  parameter int            SELW       = 3,
  parameter logic [NU-1:0] UP_PULL    = '0,
  parameter bit            DN_IS_PULL = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [SELW-1:0] sel,
  input  logic [NU-1:0]   up_stb_i,
  input  logic [NU*W-1:0] up_dat_i,
  input  logic            dn_req_i,
  output logic            dn_stb_o,
  output logic [W-1:0]    dn_dat_o,
  output logic            dn_ovr_o,
  output route_t          kind_o
);

  logic            in_range;
  logic [SELW-1:0] sel_safe;
  logic            up_stb_sel;
  logic [W-1:0]    up_dat_sel;

  assign in_range   = int'(sel) < NU;
  assign sel_safe   = in_range ? sel : '0;
  assign up_stb_sel = up_stb_i[sel_safe];
  assign up_dat_sel = up_dat_i[int'(sel_safe)*W +: W];
  assign kind_o     = classify(en, in_range, UP_PULL[sel_safe], DN_IS_PULL);

  // Holding register for push upstream -> pull downstream
  logic         cap_pend;   // strobe seen last cycle, word present now
  logic         hold_full;
  logic [W-1:0] hold_q;
  logic [W-1:0] rd_q;
  logic         is_hold;
  logic         cap_fire;
  logic         rd_fire;

  assign is_hold  = (kind_o == RT_HOLD);
  assign cap_fire = is_hold && cap_pend;
  assign rd_fire  = is_hold && dn_req_i && hold_full;
  assign dn_ovr_o = cap_fire && hold_full && !rd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pend  <= 1'b0;
      hold_full <= 1'b0;
      hold_q    <= '0;
      rd_q      <= '0;
    end else if (!is_hold) begin
      cap_pend  <= 1'b0;
      hold_full <= 1'b0;
      rd_q      <= '0;
    end else begin
      cap_pend <= up_stb_sel;
      rd_q     <= rd_fire ? hold_q : '0;
      if (cap_fire) begin
        hold_q    <= up_dat_sel;
        hold_full <= 1'b1;
      end else if (rd_fire) begin
        hold_full <= 1'b0;
      end
    end
  end

  always_comb begin
    dn_stb_o = 1'b0;
    dn_dat_o = '0;
    unique case (kind_o)
      RT_PUSH: begin
        dn_stb_o = up_stb_sel;
        dn_dat_o = up_dat_sel;
      end
      RT_PULL: dn_dat_o = up_dat_sel;
      RT_HOLD: dn_dat_o = rd_q;
      default: ;
    endcase
  end

  // R9
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_ovr_o |-> hold_full);

  // R8
  read_returns_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (kind_o != RT_HOLD || dn_dat_o == $past(hold_q)));

  // R8
  read_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !cap_fire) |=> !hold_full);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_o == RT_OFF) |-> (!dn_stb_o && dn_dat_o == '0 && !dn_ovr_o));

  // R4
  push_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stb_o |-> (kind_o == RT_PUSH && up_stb_sel));

endmodule

// File: rtl/srf_req_fanout.sv
module srf_req_fanout #(
  parameter int NU   = 6,
  parameter int ND   = 6,
  parameter int SELW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ND-1:0]      pull_route,
  input  logic [ND*SELW-1:0] sel,
  input  logic [ND-1:0]      dn_req_i,
  output logic [NU-1:0]      up_req_o
);

  always_comb begin
    up_req_o = '0;
    for (int d = 0; d < ND; d++) begin
      if (pull_route[d] && dn_req_i[d] && int'(sel[d*SELW +: SELW]) < NU)
        up_req_o[sel[d*SELW +: SELW]] = 1'b1;
    end
  end

  // R5
  req_has_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_o != '0) |-> ((dn_req_i & pull_route) != '0));

  // R6
  req_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(up_req_o) <= $countones(dn_req_i & pull_route));

endmodule

// File: rtl/stream_route_fabric.sv
module stream_route_fabric
  import srf_pkg::*;
#(
  parameter int                    NSRC    = 4,
  parameter int                    NPU     = 2,
  parameter int                    NSNK    = 4,
  parameter int                    W       = 8,
  parameter logic [NSRC+NPU-1:0]   UP_PULL = 6'b101100,
  parameter logic [NSNK+NPU-1:0]   DN_PULL = 6'b101100,
  localparam int                   NU      = NSRC + NPU,
  localparam int                   ND      = NSNK + NPU,
  localparam int                   SELW    = $clog2(NU),
  localparam int                   AW      = $clog2(ND),
  localparam int                   CW      = SELW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_wdata,
  input  logic [NU-1:0]   up_stb_i,
  output logic [NU-1:0]   up_req_o,
  input  logic [NU*W-1:0] up_dat_i,
  output logic [ND-1:0]   dn_stb_o,
  input  logic [ND-1:0]   dn_req_i,
  output logic [ND*W-1:0] dn_dat_o,
  output logic [ND-1:0]   dn_ovr_o
);

  logic [ND-1:0]      route_en;
  logic [ND*SELW-1:0] route_sel;
  logic [ND-1:0]      pull_route;

  srf_cfg_regs #(.ND(ND), .SELW(SELW), .AW(AW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .en_o  (route_en),
    .sel_o (route_sel)
  );

  for (genvar d = 0; d < ND; d++) begin : g_dn
    route_t kind;

    srf_down_port #(
      .NU(NU), .W(W), .SELW(SELW), .UP_PULL(UP_PULL), .DN_IS_PULL(DN_PULL[d])
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (route_en[d]),
      .sel      (route_sel[d*SELW +: SELW]),
      .up_stb_i (up_stb_i),
      .up_dat_i (up_dat_i),
      .dn_req_i (dn_req_i[d]),
      .dn_stb_o (dn_stb_o[d]),
      .dn_dat_o (dn_dat_o[d*W +: W]),
      .dn_ovr_o (dn_ovr_o[d]),
      .kind_o   (kind)
    );

    assign pull_route[d] = (kind == RT_PULL);
  end

  srf_req_fanout #(.NU(NU), .ND(ND), .SELW(SELW)) u_fan (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_route (pull_route),
    .sel        (route_sel),
    .dn_req_i   (dn_req_i),
    .up_req_o   (up_req_o)
  );

  // R7
  no_req_to_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_req_o & ~UP_PULL) == '0);

endmodule

// File: tb/stream_route_fabric_tb.sv
`timescale 1ns/1ps
module stream_route_fabric_tb;

  localparam int NU = 6;
  localparam int ND = 6;
  localparam int W  = 8;
  localparam logic [NU-1:0] UPP = 6'b101100;
  localparam logic [ND-1:0] DNP = 6'b101100;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_addr = '0;
  logic [3:0]      cfg_wdata = '0;
  logic [NU-1:0]   up_stb = '0;
  logic [NU-1:0]   up_req;
  logic [NU*W-1:0] up_dat = '0;
  logic [ND-1:0]   dn_stb;
  logic [ND-1:0]   dn_req = '0;
  logic [ND*W-1:0] dn_dat;
  logic [ND-1:0]   dn_ovr;

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  stream_route_fabric #(.UP_PULL(UPP), .DN_PULL(DNP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .up_stb_i(up_stb), .up_req_o(up_req),
    .up_dat_i(up_dat), .dn_stb_o(dn_stb), .dn_req_i(dn_req),
    .dn_dat_o(dn_dat), .dn_ovr_o(dn_ovr)
  );

  // Bench shadow of the route registers and holding registers
  bit           m_en   [ND];
  int           m_sel  [ND];
  bit           m_full [ND];
  bit           m_pend [ND];
  logic [W-1:0] m_hold [ND];
  logic [W-1:0] m_rd   [ND];

  // 0 idle, 1 push-push, 2 pull-pull, 3 push->pull hold
  function automatic int kind_of(int d);
    bit src_pulls, dst_pulls;
    if (!m_en[d] || m_sel[d] >= NU) return 0;
    src_pulls = UPP[m_sel[d]];
    dst_pulls = DNP[d];
    if (src_pulls == dst_pulls) return src_pulls ? 2 : 1;
    return dst_pulls ? 3 : 0;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                     input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Compare all outputs against the shadow, then advance the shadow one edge
  task automatic cycle(input string tag);
    logic [NU-1:0]   e_req;
    logic [ND-1:0]   e_stb, e_ovr;
    logic [ND*W-1:0] e_dat;
    int k, s;
    bit hit;
    #1;
    e_req = '0; e_stb = '0; e_ovr = '0; e_dat = '0;
    for (int d = 0; d < ND; d++) begin
      k = kind_of(d);
      s = m_sel[d];
      if (k == 1) begin
        e_stb[d] = up_stb[s];
        e_dat[d*W +: W] = up_dat[s*W +: W];
      end else if (k == 2) begin
        e_dat[d*W +: W] = up_dat[s*W +: W];
        if (dn_req[d]) e_req[s] = 1'b1;
      end else if (k == 3) begin
        e_dat[d*W +: W] = m_rd[d];
        e_ovr[d] = m_pend[d] && m_full[d] && !dn_req[d];
      end
    end
    chk(64'(up_req), 64'(e_req), tag, "up_req");
    chk(64'(dn_stb), 64'(e_stb), tag, "dn_stb");
    chk(64'(dn_dat), 64'(e_dat), tag, "dn_dat");
    chk(64'(dn_ovr), 64'(e_ovr), tag, "dn_ovr");
    for (int d = 0; d < ND; d++) begin
      k = kind_of(d);
      s = m_sel[d];
      if (k == 3) begin
        hit = dn_req[d] && m_full[d];
        m_rd[d] = hit ? m_hold[d] : '0;
        if (m_pend[d]) begin
          m_hold[d] = up_dat[s*W +: W];
          m_full[d] = 1'b1;
        end else if (hit) begin
          m_full[d] = 1'b0;
        end
        m_pend[d] = up_stb[s];
      end else begin
        m_full[d] = 1'b0;
        m_pend[d] = 1'b0;
        m_rd[d]   = '0;
      end
    end
    if (cfg_we && cfg_addr < ND) begin
      m_en[cfg_addr]  = cfg_wdata[3];
      m_sel[cfg_addr] = int'(cfg_wdata[2:0]);
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    cfg_we = 1'b0; up_stb = '0; dn_req = '0;
  endtask

  task automatic route(input int d, input bit en, input int s, input string tag);
    quiet();
    cfg_we = 1'b1; cfg_addr = 3'(d); cfg_wdata = {en, 3'(s)};
    cycle(tag);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < ND; d++) begin
      m_en[d] = 0; m_sel[d] = 0; m_full[d] = 0; m_pend[d] = 0;
      m_hold[d] = '0; m_rd[d] = '0;
    end
    repeat (3) @(negedge clk);
    cycle("R1");
    rst_n = 1'b1;
    cycle("R1");

    // R2: write to addresses 6 and 7 is ignored
    route(6, 1, 0, "R2");
    route(7, 1, 0, "R2");
    up_stb = 6'b000001; up_dat = {6{8'hA5}};
    cycle("R2");
    chk(64'(dn_stb), 64'd0, "R2", "dn_stb after bad address");

    // R3: enabled route with index 6 acts as disabled
    route(0, 1, 6, "R3");
    up_stb = '1; up_dat = {6{8'h3C}};
    cycle("R3");
    chk(64'(dn_dat[0 +: W]), 64'd0, "R3", "dn_dat sink0");

    // R4: sink0 (push) <- source0 (push)
    route(0, 1, 0, "R4");
    up_stb = 6'b000001; up_dat[0 +: W] = 8'h11;
    cycle("R4");
    up_stb = '0; up_dat[0 +: W] = 8'h22;
    cycle("R4");

    // R5: sinks 2 and 3 (pull) both <- source2 (pull)
    route(2, 1, 2, "R5");
    route(3, 1, 2, "R5");
    dn_req = 6'b000100;
    cycle("R5");
    dn_req = 6'b001000; up_dat[2*W +: W] = 8'h77;
    #1 chk(64'(up_req), 64'b000100, "R5", "up_req");
    cycle("R5");

    // R7: sink1 (push) <- source3 (pull)
    route(1, 1, 3, "R7");
    up_stb = '1; dn_req = '1; up_dat = {6{8'h99}};
    cycle("R7");
    chk(64'(dn_stb[1]), 64'd0, "R7", "dn_stb sink1");

    // R11: unit input 4 (push) <- source0, sink1 <- unit output 4 (push)
    route(4, 1, 0, "R11");
    route(1, 1, 4, "R11");
    up_stb = 6'b010001; up_dat[0 +: W] = 8'h5E; up_dat[4*W +: W] = 8'hE5;
    cycle("R11");
    chk(64'(dn_stb), 64'b010011, "R11", "dn_stb chain");

    // R8: sink3 (pull) <- source1 (push)
    route(3, 1, 1, "R8");
    up_stb = 6'b000010;
    cycle("R8");
    up_stb = '0; up_dat[1*W +: W] = 8'h5A;
    cycle("R8");
    dn_req = 6'b001000;
    cycle("R8");
    dn_req = '0;
    chk(64'(dn_dat[3*W +: W]), 64'h5A, "R8", "held word returned");
    cycle("R8");
    dn_req = 6'b001000;
    cycle("R8");
    dn_req = '0;
    chk(64'(dn_dat[3*W +: W]), 64'h0, "R8", "read of empty register");

    // R9: two words without a read
    up_stb = 6'b000010;
    cycle("R9");
    up_stb = 6'b000010; up_dat[1*W +: W] = 8'hC1;
    cycle("R9");
    up_stb = '0; up_dat[1*W +: W] = 8'hC2;
    #1 chk(64'(dn_ovr), 64'b001000, "R9", "overrun pulse");
    cycle("R9");
    dn_req = 6'b001000;
    cycle("R9");
    dn_req = '0;
    chk(64'(dn_dat[3*W +: W]), 64'hC2, "R9", "newest word kept");

    // R8: read and arrival in the same cycle
    up_stb = 6'b000010;
    cycle("R8");
    up_stb = 6'b000010; up_dat[1*W +: W] = 8'hD1;
    cycle("R8");
    up_stb = '0; up_dat[1*W +: W] = 8'hD2; dn_req = 6'b001000;
    cycle("R8");
    chk(64'(dn_dat[3*W +: W]), 64'hD1, "R8", "old word on overlap");
    cycle("R8");
    chk(64'(dn_dat[3*W +: W]), 64'hD2, "R8", "new word on overlap");

    // R10: reroute discards a held word
    up_stb = 6'b000010;
    cycle("R10");
    up_stb = '0; up_dat[1*W +: W] = 8'hEE;
    cycle("R10");
    route(3, 0, 1, "R10");
    route(3, 1, 1, "R10");
    dn_req = 6'b001000;
    cycle("R10");
    dn_req = '0;
    chk(64'(dn_dat[3*W +: W]), 64'h0, "R10", "discarded word");

    // Random mix of reconfiguration and traffic, R4 to R9 checked by the shadow
    for (int i = 0; i < 3000; i++) begin
      cfg_we    = ($urandom % 16) == 0;
      cfg_addr  = 3'($urandom % 8);
      cfg_wdata = 4'($urandom);
      for (int u = 0; u < NU; u++) begin
        up_stb[u] = ($urandom % 4) == 0;
        up_dat[u*W +: W] = 8'($urandom);
      end
      for (int d = 0; d < ND; d++) dn_req[d] = ($urandom % 3) == 0;
      cycle("random R6");
    end
    quiet();
    cycle("R6");
    finish_run();
  end

endmodule